// File: doc/BRIEF.md
# Partitioned Arithmetic Logic Unit

This block is the integer execution stage of a 32-bit datapath. It takes two operand buses and a 3-bit operation code. Four sub-units work side by side: one for transfer and complement, one for bitwise logic, one for a one-place left shift and one for add/subtract. Each computes its answer on every cycle. A result multiplexer chooses exactly one of those answers, and the result and its flags are captured in an output register. The carry and signed-overflow flags come from the adder's carry chain. They are meaningful only for the two arithmetic codes and read as zero for every other code.

Beside the main datapath there is a small address-operand path. It widens a 16-bit immediate to 32 bits by copying its sign bit. It also gives that widened value multiplied by four, which is a fixed two-place rewiring. Both helper values are registered with the same one-cycle latency as the result, so address arithmetic downstream sees them aligned with the ALU output.

Top module: `alu_part_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every output is 0 after that edge.
- R2: Op 000 gives `opa` and op 001 gives the bitwise complement of `opa`. For both codes, `opb` has no effect on any output.
- R3: Op 010 gives `opa & opb`, op 011 gives `opa | opb` and op 100 gives `opa ^ opb`.
- R4: Op 101 gives `(opa + opb) mod 2^32`, and `carry` is bit 32 of the full sum.
- R5: Op 110 gives `(opa - opb) mod 2^32`, formed as `opa + ~opb + 1`. `carry` is the carry out of that sum, so it is 1 exactly when `opa >= opb` as unsigned numbers.
- R6: For ops 101 and 110, `ovf` is 1 exactly when the signed two's-complement result is out of range. For example, 0x60000000 + 0x60000000 sets it.
- R7: Op 111 gives `opa` shifted left by one place, with a 0 in bit 0 and the old bit 31 dropped.
- R8: For every op other than 101 and 110, `carry` and `ovf` are 0.
- R9: `zero` is 1 exactly when all 32 bits of `result` are 0.
- R10: `imm_sext` equals `imm` with bit 15 copied into bits 31..16.
- R11: `imm_addr` equals `imm_sext` shifted left by two places, with bits 1..0 equal to 0.
- R12: Outputs appear one clock after the inputs are presented. The values sampled at a rising edge with `rst_n` high are on the outputs after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| opa | input | 32 | First operand bus |
| opb | input | 32 | Second operand bus |
| op | input | 3 | Operation code |
| imm | input | 16 | Immediate for the address path |
| result | output | 32 | Registered selected result |
| carry | output | 1 | Carry out of bit 31 (arithmetic only) |
| ovf | output | 1 | Signed overflow (arithmetic only) |
| zero | output | 1 | Result is all zeros |
| imm_sext | output | 32 | Sign-extended immediate |
| imm_addr | output | 32 | Sign-extended immediate times four |

## Verification
Since the block holds no state beyond its output register, any fault in a sub-unit, the result select or the carry chain shows up on the ports in the very next cycle. It appears as a wrong result or flag for the vector just applied. A broken carry into bit 31 shows only on operands whose top bits interact. For that reason, directed sign-boundary sums and differences are mixed into the random stream. A select fault that leaks the second bus into a one-operand code is exposed by applying the same first operand with two different second operands.

// File: rtl/alu_part_pkg.sv
// Shared definitions for the partitioned ALU.
// Assumes: the operation code is exactly 3 bits wide.
package alu_part_pkg;

    typedef enum logic [2:0] {
        OP_PASS = 3'b000,
        OP_NOT  = 3'b001,
        OP_AND  = 3'b010,
        OP_OR   = 3'b011,
        OP_XOR  = 3'b100,
        OP_ADD  = 3'b101,
        OP_SUB  = 3'b110,
        OP_SLL1 = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_fn_e;

endpackage

// File: rtl/alu_xfer_unit.sv
// Transfer/complement sub-unit: passes operand A, or its complement, through.
// Assumes: only the first operand bus matters; there is no second input at all.
module alu_xfer_unit #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic         invert,
    output logic [W-1:0] y
);
    // one controlled inverter per bit
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign y[i] = a[i] ^ invert;
    end
endmodule

// File: rtl/alu_logic_unit.sv
// Bitwise logic sub-unit: AND, OR or XOR of the two operands.
// Assumes: the function code is one of the three defined encodings.
module alu_logic_unit
    import alu_part_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_fn_e    fn,
    output logic [W-1:0] y
);
    // choose the bitwise function
    always_comb begin
        unique case (fn)
            LG_AND:  y = a & b;
            LG_OR:   y = a | b;
            default: y = a ^ b;
        endcase
    end
endmodule

// File: rtl/alu_shift_unit.sv
// Shift sub-unit: fixed left shift of A by one place, filled with zero.
// Assumes: W >= 2; the bit leaving the top is discarded.
module alu_shift_unit #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    output logic [W-1:0] y
);
    assign y[0] = 1'b0;
    // rewire each bit up by one place
    for (genvar i = 1; i < W; i++) begin : g_bit
        assign y[i] = a[i-1];
    end
endmodule

// File: rtl/alu_addsub_unit.sv
// Add/subtract sub-unit: a ripple chain of full adders. When sub is set, B is
// inverted bit by bit and sub enters as the carry-in, giving A + ~B + 1.
// Assumes: W >= 2; the carries into and out of the top bit are both brought out.
module alu_addsub_unit #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         cin_msb
);
    logic [W:0] c;
    assign c[0] = sub;

    // one full adder per bit, B conditionally inverted
    for (genvar i = 0; i < W; i++) begin : g_fa
        logic bx;
        assign bx     = b[i] ^ sub;
        assign sum[i] = a[i] ^ bx ^ c[i];
        assign c[i+1] = (a[i] & bx) | (a[i] & c[i]) | (bx & c[i]);
    end

    assign cout    = c[W];
    assign cin_msb = c[W-1];
endmodule

// File: rtl/alu_part_top.sv
// Partitioned ALU top: four sub-units feed a result select. The result, the
// flags and the immediate helper outputs are registered with a synchronous
// active-low reset.
// Assumes: W > IMM_W; carry and overflow mean something only for add/subtract.
module alu_part_top
    import alu_part_pkg::*;
#(
    parameter int W     = 32,
    parameter int IMM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     opa,
    input  logic [W-1:0]     opb,
    input  logic [2:0]       op,
    input  logic [IMM_W-1:0] imm,
    output logic [W-1:0]     result,
    output logic             carry,
    output logic             ovf,
    output logic             zero,
    output logic [W-1:0]     imm_sext,
    output logic [W-1:0]     imm_addr
);
    localparam int EXT_W     = W - IMM_W;
    localparam int ADDR_SHFT = 2;

    alu_op_e   op_e;
    logic_fn_e lg_fn;
    logic      is_arith;
    logic      is_sub;
    logic [W-1:0] y_xfer, y_logic, y_shift, y_sum;
    logic         a_cout, a_cin_msb;
    logic [W-1:0] nxt_result;
    logic [W-1:0] nxt_sext, nxt_addr;

    assign op_e     = alu_op_e'(op);
    assign is_sub   = (op_e == OP_SUB);
    assign is_arith = (op_e == OP_ADD) || (op_e == OP_SUB);

    // map the operation code to a logic-unit function
    always_comb begin
        unique case (op_e)
            OP_AND:  lg_fn = LG_AND;
            OP_OR:   lg_fn = LG_OR;
            default: lg_fn = LG_XOR;
        endcase
    end

    alu_xfer_unit #(.W(W)) u_xfer (
        .a(opa), .invert(op_e == OP_NOT), .y(y_xfer)
    );

    alu_logic_unit #(.W(W)) u_logic (
        .a(opa), .b(opb), .fn(lg_fn), .y(y_logic)
    );

    alu_shift_unit #(.W(W)) u_shift (
        .a(opa), .y(y_shift)
    );

    alu_addsub_unit #(.W(W)) u_addsub (
        .a(opa), .b(opb), .sub(is_sub),
        .sum(y_sum), .cout(a_cout), .cin_msb(a_cin_msb)
    );

    // result select: exactly one sub-unit reaches the output
    always_comb begin
        unique case (op_e)
            OP_PASS, OP_NOT:        nxt_result = y_xfer;
            OP_AND, OP_OR, OP_XOR:  nxt_result = y_logic;
            OP_ADD, OP_SUB:         nxt_result = y_sum;
            default:                nxt_result = y_shift;
        endcase
    end

    // address-operand helper: sign extension, then a fixed two-place rewire
    assign nxt_sext = {{EXT_W{imm[IMM_W-1]}}, imm};
    assign nxt_addr = {nxt_sext[W-1-ADDR_SHFT:0], {ADDR_SHFT{1'b0}}};

    // output register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result   <= '0;
            carry    <= 1'b0;
            ovf      <= 1'b0;
            zero     <= 1'b0;
            imm_sext <= '0;
            imm_addr <= '0;
        end else begin
            result   <= nxt_result;
            carry    <= is_arith & a_cout;
            ovf      <= is_arith & (a_cout ^ a_cin_msb);
            zero     <= ~|nxt_result;
            imm_sext <= nxt_sext;
            imm_addr <= nxt_addr;
        end
    end
endmodule

// File: rtl/alu_part_chk.sv
// Assertion checker for alu_part_top, attached through bind.
// Assumes: the outputs trail the inputs by one clock; armed marks the cycles in
// which the previous inputs were sampled out of reset.
module alu_part_chk
    import alu_part_pkg::*;
#(
    parameter int W     = 32,
    parameter int IMM_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [W-1:0]     opa,
    input logic [W-1:0]     opb,
    input logic [2:0]       op,
    input logic [IMM_W-1:0] imm,
    input logic [W-1:0]     result,
    input logic             carry,
    input logic             ovf,
    input logic             zero,
    input logic [W-1:0]     imm_sext,
    input logic [W-1:0]     imm_addr
);
    localparam int EXT_W = W - IMM_W;

    logic armed;

    // set once one clock has been sampled with reset released
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (zero == (result == '0))); // R9

    AST_NOT_IGNORES_B: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op) == OP_NOT) |-> (result == ~$past(opa))); // R2

    AST_NO_FLAGS_NONARITH: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op) != OP_ADD && $past(op) != OP_SUB) |-> (!carry && !ovf)); // R8

    AST_ADD_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op) == OP_ADD) |->
        (ovf == (($past(opa[W-1]) == $past(opb[W-1])) && (result[W-1] != $past(opa[W-1]))))); // R6

    AST_SIGN_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (imm_sext == {{EXT_W{$past(imm[IMM_W-1])}}, $past(imm)})); // R10

    AST_ADDR_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (imm_addr == {imm_sext[W-3:0], 2'b00})); // R11
endmodule

bind alu_part_top alu_part_chk #(.W(W), .IMM_W(IMM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .op(op), .imm(imm),
    .result(result), .carry(carry), .ovf(ovf), .zero(zero),
    .imm_sext(imm_sext), .imm_addr(imm_addr)
);

// File: tb/alu_part_top_bench.sv
// Self-checking bench: directed corner cases plus seeded random vectors, each
// compared against a reference model written from the requirements.
module alu_part_top_bench;
    localparam int W = 32;
    localparam int IMM_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [W-1:0]     opa = '0, opb = '0;
    logic [2:0]       op = '0;
    logic [IMM_W-1:0] imm = '0;
    logic [W-1:0]     result, imm_sext, imm_addr;
    logic             carry, ovf, zero;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    alu_part_top #(.W(W), .IMM_W(IMM_W)) u_alu_part_top (
        .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .op(op), .imm(imm),
        .result(result), .carry(carry), .ovf(ovf), .zero(zero),
        .imm_sext(imm_sext), .imm_addr(imm_addr)
    );

    // reference model: {carry, ovf, zero, result}
    function automatic logic [W+2:0] model(input logic [2:0] o, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0]   s;
        logic [W-1:0] r;
        logic         c, v;
        c = 1'b0; v = 1'b0;
        case (o)
            3'b000: r = a;                                   // R2
            3'b001: r = ~a;                                  // R2
            3'b010: r = a & b;                               // R3
            3'b011: r = a | b;                               // R3
            3'b100: r = a ^ b;                               // R3
            3'b101: begin                                    // R4
                s = {1'b0, a} + {1'b0, b};
                r = s[W-1:0]; c = s[W];
                v = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]); // R6
            end
            3'b110: begin                                    // R5
                r = a - b; c = (a >= b);
                v = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]); // R6
            end
            default: r = {a[W-2:0], 1'b0};                   // R7
        endcase
        return {c, v, (r == '0), r};                         // R9
    endfunction

    function automatic logic [W-1:0] sext(input logic [IMM_W-1:0] i);
        return {{(W-IMM_W){i[IMM_W-1]}}, i};
    endfunction

    task automatic chk(input string req, input logic [W+2:0] act, input logic [W+2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one vector at a falling edge, let it be captured, sample at the next falling edge
    task automatic apply(input string req, input logic [2:0] o, input logic [W-1:0] a,
                         input logic [W-1:0] b, input logic [IMM_W-1:0] i);
        op = o; opa = a; opb = b; imm = i;
        @(posedge clk);
        @(negedge clk);
        chk(req, {carry, ovf, zero, result}, model(o, a, b));                // R12
        chk({req, " imm R10"}, {3'b000, imm_sext}, {3'b000, sext(i)});       // R10
        chk({req, " addr R11"}, {3'b000, imm_addr}, {3'b000, sext(i) << 2}); // R11
    endtask

    // watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd5155);
        // R1: outputs held clear during reset, even with live inputs
        op = 3'b101; opa = 32'hFFFF_FFFF; opb = 32'h1; imm = 16'h8001;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset", {carry, ovf, zero, result}, '0);
        chk("R1 reset imm", {3'b000, imm_sext | imm_addr}, '0);
        rst_n = 1'b1;

        // R2: B has no effect on the one-operand codes
        apply("R2 pass", 3'b000, 32'hA5A5_0F0F, 32'h0000_0000, 16'h0004);
        apply("R2 pass B changed", 3'b000, 32'hA5A5_0F0F, 32'hFFFF_FFFF, 16'h0004);
        apply("R2 not", 3'b001, 32'h1234_5678, 32'h0, 16'h7FFF);
        apply("R2 not B changed", 3'b001, 32'h1234_5678, 32'hDEAD_BEEF, 16'h7FFF);
        apply("R2 R9 not zero", 3'b001, 32'hFFFF_FFFF, 32'h1, 16'h8000);
        // R3
        apply("R3 and", 3'b010, 32'hF0F0_FFFF, 32'h0FF0_1234, 16'h0);
        apply("R3 or", 3'b011, 32'hF000_0000, 32'h0000_000F, 16'hFFFF);
        apply("R3 xor zero", 3'b100, 32'h5555_AAAA, 32'h5555_AAAA, 16'h1);
        // R4 R6
        apply("R6 add overflow", 3'b101, 32'h6000_0000, 32'h6000_0000, 16'h0);
        apply("R4 R6 add carry ovf zero", 3'b101, 32'h8000_0000, 32'h8000_0000, 16'h0);
        apply("R4 add carry no ovf", 3'b101, 32'hFFFF_FFFF, 32'h0000_0001, 16'h0);
        // R5 R6
        apply("R5 R6 sub overflow", 3'b110, 32'h8000_0000, 32'h0000_0001, 16'h0);
        apply("R5 sub equal", 3'b110, 32'h1234_5678, 32'h1234_5678, 16'h0);
        apply("R5 sub borrow", 3'b110, 32'h0, 32'h1, 16'h0);
        // R7 R8
        apply("R7 R8 sll drop top", 3'b111, 32'h8000_0000, 32'hFFFF_FFFF, 16'h0);
        apply("R7 sll", 3'b111, 32'h4000_0001, 32'h0, 16'hC000);

        // random vectors, op-weighted by uniform choice
        for (int k = 0; k < 3000; k++) begin
            logic [W-1:0] ra, rb;
            ra = $urandom();
            rb = $urandom();
            if (k % 7 == 0) rb = ra;
            apply("R3 R4 R5 R8 random", 3'($urandom_range(0, 7)), ra, rb, 16'($urandom()));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule